// File: doc/BRIEF.md
# Dual Timestamp Alarm Comparator

This block watches a free-running time counter supplied from outside and compares it against two alarm channels, each holding a compare value as wide as the counter. When an armed channel sees the counter reach or pass its compare value, the block does three things. It drives that channel's alarm pin for one clock, with a polarity chosen per channel. It latches a sticky event bit. Through a per-bit mask, that event bit can raise a single interrupt line.

Software configures the block through a flat register port. The port has a write strobe with address and data, and a combinational read address with read data. A compare value is twice the width of the data port, so it is loaded as a staged low half followed by a high half. Writing the high half commits the whole value in one step and arms the channel. After firing, a channel stays quiet until its high half is written again. Event bits are cleared by writing ones to them.

Top module: `tsalarm_unit`

## Requirements
- R1: There are two alarm channels, and the register map is as follows. Address 0 holds polarity. Address 1 holds events. Address 2 holds the mask. Channel c's low half is at address 4+2c and its high half at 4+2c+1. Reads of any other address return zero.
- R2: A low-half write is only staged. The readable compare value and the value used for matching change only when the high half is written. That write commits {high, staged low} and arms the channel. A high-half write on its own reuses the last staged low half.
- R3: After reset, both halves of each compare value read as all ones and both channels are disarmed. No pin pulses even with the counter at its maximum. Polarity, event and mask registers all read zero.
- R4: Take the first clock edge at which an armed channel samples counter >= compare value. In the cycle after that edge the channel pulses for exactly one clock and disarms. It does not pulse again until its high half is written.
- R5: Polarity bit c (bit 0 for channel 0, bit 1 for channel 1) selects the pin's sense. A value of 1 makes the pin active-low, so it idles high and drops during a pulse. A value of 0 makes it active-high.
- R6: A firing sets event bit c (bit 0 for channel 0, bit 1 for channel 1), and the bit becomes readable in the same cycle the pulse appears.
- R7: Writing the event register clears the bits written as 1 and leaves the bits written as 0. Writing all ones clears every event.
- R8: If a channel fires on the same edge that a write of 1 clears its event bit, the bit ends up set.
- R9: The interrupt is high exactly when some event bit is set and its mask bit is set. Mask bit c gates event bit c, and the mask resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | CNT_W | Current value of the free-running time counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | HALF_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | HALF_W | Register read data, combinational |
| alarm_pin | output | NUM_CH | Alarm outputs, one per channel, polarity applied |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the block with CNT_W=16 and HALF_W=8. This keeps NUM_CH=2, ADDR_W=4 and the greater-or-equal comparator. At that width the counter's maximum value and the carry between compare halves sit within a few cycles of stepping. This lets the bench sweep dozens of compare values per channel, with counter strides from 1 to 5, so the bench covers both exact hits and the counter jumping past the value. The bench computes each expected pin level from the counter sequence it drives. The narrow halves also make the staged-low and commit-on-high ordering easy to provoke, as they do the set-versus-clear collision on the event register.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   // register offsets; the channel pair layout is decoded by the top
   localparam int unsigned OFS_POL      = 0;
   localparam int unsigned OFS_EVT      = 1;
   localparam int unsigned OFS_MASK     = 2;
   localparam int unsigned OFS_CH_BASE  = 4;

   function automatic int unsigned ch_lo_ofs(input int unsigned ch);
      return OFS_CH_BASE + 2 * ch;
   endfunction

   function automatic int unsigned ch_hi_ofs(input int unsigned ch);
      return OFS_CH_BASE + 2 * ch + 1;
   endfunction

   typedef enum logic {
      PIN_ACT_HIGH = 1'b0,
      PIN_ACT_LOW  = 1'b1
   } pin_sense_e;
endpackage

// File: rtl/tsa_alarm_chan.sv
module tsa_alarm_chan #(
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned HALF_W   = 32,
   parameter bit          GE_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_wr,
   input  logic              hi_wr,
   input  logic [HALF_W-1:0] wr_half,
   input  logic [CNT_W-1:0]  time_now,
   output logic [CNT_W-1:0]  cmp_val,
   output logic              hit,
   output logic              pulse
);
   logic [HALF_W-1:0] staged_lo;
   logic [CNT_W-1:0]  cmp_q;
   logic              arm_q;
   logic              pulse_q;
   logic              reach;

   generate
      if (GE_MATCH) begin : g_ge
         assign reach = (time_now >= cmp_q);
      end else begin : g_eq
         assign reach = (time_now == cmp_q);
      end
   endgenerate

   assign hit = arm_q && reach;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_lo <= '1;
         cmp_q     <= '1;
         arm_q     <= 1'b0;
         pulse_q   <= 1'b0;
      end else begin
         if (lo_wr) staged_lo <= wr_half;
         if (hi_wr) cmp_q <= {wr_half, staged_lo};
         if (hi_wr)    arm_q <= 1'b1;
         else if (hit) arm_q <= 1'b0;
         pulse_q <= hit;
      end
   end

   assign cmp_val = cmp_q;
   assign pulse   = pulse_q;

   AST_COMMIT_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_wr |=> $stable(cmp_q)) else $error("compare changed without high write"); // R2
   AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !hi_wr) |=> !arm_q) else $error("channel stayed armed after firing"); // R4
   AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_q |=> !pulse_q) else $error("pulse from disarmed channel"); // R4
endmodule

// File: rtl/tsa_event_ctrl.sv
module tsa_event_ctrl #(
   parameter int unsigned NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_bits,
   input  logic [NUM_CH-1:0] clr_bits,
   input  logic              mask_wr,
   input  logic [NUM_CH-1:0] mask_data,
   output logic [NUM_CH-1:0] evt_q,
   output logic [NUM_CH-1:0] mask_q,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         mask_q <= '0;
      end else begin
         evt_q <= (evt_q & ~clr_bits) | set_bits;
         if (mask_wr) mask_q <= mask_data;
      end
   end

   assign irq = |(evt_q & mask_q);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_q[i] && !clr_bits[i]) |=> evt_q[i]) else $error("event lost"); // R7
         AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_bits[i] && !set_bits[i]) |=> !evt_q[i]) else $error("clear ignored"); // R7
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_bits[i] |=> evt_q[i]) else $error("set lost to clear"); // R8
      end
   endgenerate

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq) else $error("irq with empty mask"); // R9
endmodule

// File: rtl/tsa_pin_drive.sv
module tsa_pin_drive #(
   parameter int unsigned NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pol_wr,
   input  logic [NUM_CH-1:0] pol_data,
   input  logic [NUM_CH-1:0] pulse,
   output logic [NUM_CH-1:0] pol_q,
   output logic [NUM_CH-1:0] pin
);
   import tsa_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pol_q <= '0;
      else if (pol_wr) pol_q <= pol_data;
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
         pin_sense_e sense;
         assign sense  = pin_sense_e'(pol_q[i]);
         assign pin[i] = (sense == PIN_ACT_LOW) ? ~pulse[i] : pulse[i];

         AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !pulse[i] |-> (pin[i] == pol_q[i])) else $error("idle pin level wrong"); // R5
      end
   endgenerate
endmodule

// File: rtl/tsalarm_unit.sv
module tsalarm_unit #(
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned HALF_W   = 32,
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          GE_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  time_now,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [HALF_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [HALF_W-1:0] rd_data,
   output logic [NUM_CH-1:0] alarm_pin,
   output logic              irq
);
   import tsa_pkg::*;

   localparam int unsigned MAP_TOP = OFS_CH_BASE + 2 * NUM_CH;

   generate
      if (CNT_W != 2 * HALF_W) begin : g_bad_width
         $error("CNT_W must be twice HALF_W");
      end
      if (NUM_CH < 1 || NUM_CH > HALF_W) begin : g_bad_ch
         $error("NUM_CH must be 1..HALF_W");
      end
      if (MAP_TOP > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for register map");
      end
   endgenerate

   logic              pol_wr, evt_wr, mask_wr;
   logic [NUM_CH-1:0] lo_wr, hi_wr;
   logic [NUM_CH-1:0] hit, pulse;
   logic [NUM_CH-1:0] pol_q, evt_q, mask_q;
   logic [NUM_CH-1:0] clr_bits;
   logic [CNT_W-1:0]  cmp_val [NUM_CH];

   assign pol_wr  = wr_en && (wr_addr == ADDR_W'(OFS_POL));
   assign evt_wr  = wr_en && (wr_addr == ADDR_W'(OFS_EVT));
   assign mask_wr = wr_en && (wr_addr == ADDR_W'(OFS_MASK));
   assign clr_bits = evt_wr ? wr_data[NUM_CH-1:0] : '0;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign lo_wr[c] = wr_en && (wr_addr == ADDR_W'(ch_lo_ofs(c)));
         assign hi_wr[c] = wr_en && (wr_addr == ADDR_W'(ch_hi_ofs(c)));

         tsa_alarm_chan #(
            .CNT_W    (CNT_W),
            .HALF_W   (HALF_W),
            .GE_MATCH (GE_MATCH)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .lo_wr    (lo_wr[c]),
            .hi_wr    (hi_wr[c]),
            .wr_half  (wr_data),
            .time_now (time_now),
            .cmp_val  (cmp_val[c]),
            .hit      (hit[c]),
            .pulse    (pulse[c])
         );
      end
   endgenerate

   tsa_event_ctrl #(.NUM_CH(NUM_CH)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_bits  (hit),
      .clr_bits  (clr_bits),
      .mask_wr   (mask_wr),
      .mask_data (wr_data[NUM_CH-1:0]),
      .evt_q     (evt_q),
      .mask_q    (mask_q),
      .irq       (irq)
   );

   tsa_pin_drive #(.NUM_CH(NUM_CH)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pol_wr   (pol_wr),
      .pol_data (wr_data[NUM_CH-1:0]),
      .pulse    (pulse),
      .pol_q    (pol_q),
      .pin      (alarm_pin)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(OFS_POL))  rd_data[NUM_CH-1:0] = pol_q;
      if (rd_addr == ADDR_W'(OFS_EVT))  rd_data[NUM_CH-1:0] = evt_q;
      if (rd_addr == ADDR_W'(OFS_MASK)) rd_data[NUM_CH-1:0] = mask_q;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_addr == ADDR_W'(ch_lo_ofs(c))) rd_data = cmp_val[c][HALF_W-1:0];
         if (rd_addr == ADDR_W'(ch_hi_ofs(c))) rd_data = cmp_val[c][CNT_W-1:HALF_W];
      end
   end

   AST_EVT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|pulse) |-> ((evt_q & pulse) == pulse)) else $error("pulse without event"); // R6
   AST_NO_PIN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pulse == '0)) else $error("pulse straight out of reset"); // R3
endmodule

// File: tb/sim_tsalarm_unit.sv
`timescale 1ns/1ps
module sim_tsalarm_unit;
   localparam int CW = 16, HW = 8, NC = 2, AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] time_now = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [HW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [HW-1:0] rd_data;
   logic [NC-1:0] alarm_pin;
   logic          irq;

   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   tsalarm_unit #(.CNT_W(CW), .HALF_W(HW), .NUM_CH(NC), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .time_now(time_now), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .alarm_pin(alarm_pin), .irq(irq));

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = HW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      rd_addr = AW'(a);
      #1;
      d = int'(rd_data);
   endtask

   task automatic arm(input int ch, input int v);
      wr(4 + 2 * ch, v & 8'hFF);
      wr(5 + 2 * ch, (v >> 8) & 8'hFF);
   endtask

   // sweep counter across v with given stride, expect exactly one pulse
   task automatic sweep(input int ch, input int v, input int step, input int pol);
      int start;
      bit fired;
      int d;
      start = v - 3 * step;
      time_now = CW'(start);
      arm(ch, v);
      fired = 1'b0;
      for (int t = start; t <= v + 3 * step && t <= 65535; t += step) begin
         bit e;
         time_now = CW'(t);
         @(negedge clk);
         e = !fired && (t >= v);
         if (e) fired = 1'b1;
         chk($sformatf("R4/R5 ch%0d v=%0h t=%0h", ch, v, t), alarm_pin[ch], e ^ pol[0]);
      end
      rd(1, d);
      chk("R6 event after sweep", (d >> ch) & 1, 1);
      wr(1, 8'hFF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 reset state
      for (int a = 4; a < 8; a++) begin
         rd(a, d);
         chk($sformatf("R3 reset half addr %0d", a), d, 8'hFF);
      end
      rd(0, d); chk("R3 reset polarity", d, 0);
      rd(1, d); chk("R3 reset events", d, 0);
      rd(2, d); chk("R3 reset mask", d, 0);
      chk("R3 reset irq", irq, 0);
      time_now = 16'hFFFF;
      repeat (4) begin
         @(negedge clk);
         chk("R3 disarmed at max count", alarm_pin, 0);
      end
      rd(1, d); chk("R3 no event while disarmed", d, 0);

      // R1 map readback and unmapped address
      time_now = 16'h0000;
      wr(6, 8'hA5); wr(7, 8'h5A);
      rd(6, d); chk("R1 ch1 low readback", d, 8'hA5);
      rd(7, d); chk("R1 ch1 high readback", d, 8'h5A);
      rd(3, d); chk("R1 unmapped reads zero", d, 0);
      rd(12, d); chk("R1 unmapped high addr", d, 0);
      time_now = 16'h5A00; // below 5AA5
      wr(7, 8'hFF);        // park ch1: commits FFA5
      wr(5, 8'hFF);        // park ch0: commits FFFF (staged low still FF)

      // R5 polarity idle levels
      wr(0, 3);
      rd(0, d); chk("R5 polarity readback", d, 3);
      chk("R5 both active-low idle high", alarm_pin, 2'b11);
      wr(0, 1);
      chk("R5 only ch0 active-low", alarm_pin, 2'b01);
      wr(0, 0);
      chk("R5 both active-high idle low", alarm_pin, 2'b00);

      // R2 staged low and commit on high
      time_now = 16'h0000;
      arm(0, 16'h1234);
      wr(4, 8'h99);
      rd(4, d); chk("R2 low staged not visible", d, 8'h34);
      time_now = 16'h1240;
      @(negedge clk);
      chk("R2 old value still matches", alarm_pin[0], 1);
      rd(1, d); chk("R6 event with pulse", d & 1, 1);
      @(negedge clk);
      chk("R4 pulse one cycle", alarm_pin[0], 0);
      wr(5, 8'h12);
      rd(4, d); chk("R2 low visible after high", d, 8'h99);
      @(negedge clk);
      chk("R2 new value not yet reached", alarm_pin[0], 0);
      time_now = 16'h1299;
      @(negedge clk);
      chk("R2 committed value fires", alarm_pin[0], 1);
      repeat (3) begin
         @(negedge clk);
         chk("R4 no re-fire", alarm_pin[0], 0);
      end
      time_now = 16'h0000;
      wr(5, 8'h12); // high only, reuses staged 99
      time_now = 16'h1299;
      @(negedge clk);
      chk("R2 high-only write rearms", alarm_pin[0], 1);
      wr(1, 8'hFF);

      // R4 immediate fire when value already reached
      time_now = 16'h0000;
      arm(1, 0);
      @(negedge clk);
      chk("R4 value zero fires after arm", alarm_pin[1], 1);
      @(negedge clk);
      chk("R4 value zero single pulse", alarm_pin[1], 0);
      wr(1, 8'hFF);

      // R4/R5 sweeps
      wr(0, 2);
      for (int k = 0; k < 24; k++) begin
         sweep(0, 40 + k * 2711, 1 + (k % 5), 0);
         sweep(1, 40 + k * 2711 + 7, 1 + ((k + 2) % 5), 1);
      end
      sweep(0, 16'h0100, 1, 0);
      sweep(1, 16'h01FF, 1, 1);
      sweep(0, 16'hFF00, 2, 0);
      sweep(1, 16'hFFFF, 1, 1);
      sweep(0, 16'hFFFF, 1, 0);
      wr(0, 0);

      // R7 write-one-to-clear
      time_now = 16'h0000;
      arm(0, 16'h0010); arm(1, 16'h0010);
      time_now = 16'h0020;
      @(negedge clk);
      rd(1, d); chk("R6 both events set", d, 3);
      wr(1, 1);
      rd(1, d); chk("R7 clear bit0 only", d, 2);
      wr(1, 0);
      rd(1, d); chk("R7 zero write keeps", d, 2);

      // R9 mask and interrupt
      wr(2, 1);
      chk("R9 masked-out event no irq", irq, 0);
      rd(2, d); chk("R9 mask readback", d, 1);
      wr(2, 2);
      chk("R9 unmasked event irq", irq, 1);
      wr(1, 8'hFF);
      rd(1, d); chk("R7 all ones clears", d, 0);
      chk("R9 irq drops with event", irq, 0);

      // R8 set wins over clear
      time_now = 16'h0000;
      arm(0, 16'h0064);
      wr(2, 1);
      time_now = 16'h0063;
      @(negedge clk);
      time_now = 16'h0064;
      wr_en = 1'b1; wr_addr = AW'(1); wr_data = 8'h01;
      @(negedge clk);
      wr_en = 1'b0;
      rd(1, d); chk("R8 set beats clear", d & 1, 1);
      chk("R9 irq from ch0 event", irq, 1);
      wr(1, 1);
      rd(1, d); chk("R7 later clear works", d, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule